// File: doc/BRIEF.md
# NRZ to Manchester Line Encoder

This block converts a serial NRZ bit stream into a Manchester-coded stream. It runs from a clock at twice the data rate, so every data bit arrives as two identical consecutive samples on `nrz_in`. A three-phase controller sits at a bit-start phase, reads the first sample and drives the first half-bit, then moves to a tail phase. In the tail phase it reads the second sample and drives the complementary half-bit. It then returns to bit start for the next pair. A data 0 leaves as low-then-high, and a data 1 leaves as high-then-low.

A second sample that differs from the first (1 after a first-half 0, or 0 after a first-half 1) breaks the pairing rule. The block drives the line low for that half-bit, pulses `code_err` for one cycle and returns to bit start. A parameter selects the output timing. With `REG_OUT` = 0 the line is a combinational function of the phase and the current sample. With `REG_OUT` = 1 the same waveform and error pulse come out of flops one clock later.

The line is a clocked serial wire that cannot be stalled, so it carries no valid/ready pair and has no back-pressure. Whatever source drives `nrz_in` must supply one sample on every clock, and whatever consumes `man_out` must accept one half-bit on every clock. Reset is synchronous and active high.

Top module: `mce_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to bit start, and `man_out` and `code_err` read 0 (in the same cycle when `REG_OUT`=0, from the following cycle when `REG_OUT`=1). Reset takes priority over error detection.
- R2: A data 0 presented as samples 0,0 produces `man_out` 0 in the first half and 1 in the second half.
- R3: A data 1 presented as samples 1,1 produces `man_out` 1 in the first half and 0 in the second half.
- R4: After every second sample, legal or not, the next sample is treated as the first half of a new bit.
- R5: A second sample of 1 after a first-half 0, or of 0 after a first-half 1, drives `man_out` to 0 and `code_err` to 1 for that half-bit only.
- R6: `code_err` is 0 on every first-half sample and on every legal second-half sample.
- R7: With `REG_OUT`=1, `man_out` and `code_err` repeat exactly the `REG_OUT`=0 waveform delayed by one clock.
- R8: The first sample after reset is released is a first half, even if reset was asserted in the middle of a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit clock, twice the data rate |
| rst | input | 1 | Synchronous reset, active high |
| nrz_in | input | 1 | NRZ sample, each bit held for two clocks |
| man_out | output | 1 | Manchester half-bit line |
| code_err | output | 1 | One-cycle pulse on a broken bit pair |

## Verification
Two things can happen in the same cycle: an illegal second sample and a synchronous reset. The bench drives a broken tail (1 after a first-half 0, and 0 after a first-half 1) while `rst` is high. It expects the reset to win: no error pulse, the line low, and a clean first half on the next sample. The bench also runs a legal pair straight after a broken one. This shows that the error cycle returns the controller to bit start without swallowing the next bit. Both timing variants run side by side, so every cycle also checks that the registered output lags the combinational one by exactly one clock.

// File: rtl/mce_pkg.sv
package mce_pkg;
  typedef enum logic [1:0] {
    PH_START     = 2'b00,
    PH_ZERO_TAIL = 2'b01,
    PH_ONE_TAIL  = 2'b10
  } phase_t;
endpackage

// File: rtl/mce_next_phase.sv
// Next-phase and half-bit decode for the encoder controller.
module mce_next_phase
  import mce_pkg::*;
(
  input  phase_t cur,
  input  logic   bit_in,
  output phase_t nxt,
  output logic   line,
  output logic   bad
);
  always_comb begin
    nxt  = PH_START;
    line = 1'b0;
    bad  = 1'b0;
    unique case (cur)
      PH_START: begin
        line = bit_in;
        nxt  = bit_in ? PH_ONE_TAIL : PH_ZERO_TAIL;
      end
      PH_ZERO_TAIL: begin
        // legal tail of a 0 is another 0, driven as the high half
        line = ~bit_in;
        bad  = bit_in;
      end
      PH_ONE_TAIL: begin
        // legal tail of a 1 is drawn low; a broken tail is low too
        line = 1'b0;
        bad  = ~bit_in;
      end
      default: begin
        nxt  = PH_START;
        line = 1'b0;
        bad  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mce_phase_reg.sv
// Phase register with synchronous reset to bit start.
module mce_phase_reg
  import mce_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t d,
  output phase_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= PH_START;
    else     q <= d;
  end
endmodule

// File: rtl/mce_encoder.sv
// NRZ to Manchester encoder, combinational or registered line output.
module mce_encoder
  import mce_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nrz_in,
  output logic man_out,
  output logic code_err
);
  phase_t phase_q;
  phase_t phase_d;
  logic   line_c;
  logic   bad_c;
  logic   line_g;
  logic   bad_g;

  mce_next_phase u_next (
    .cur    (phase_q),
    .bit_in (nrz_in),
    .nxt    (phase_d),
    .line   (line_c),
    .bad    (bad_c)
  );

  mce_phase_reg u_phase (
    .clk (clk),
    .rst (rst),
    .d   (phase_d),
    .q   (phase_q)
  );

  // reset wins over every decode result
  assign line_g = line_c & ~rst;
  assign bad_g  = bad_c  & ~rst;

  generate
    if (REG_OUT) begin : g_flopped
      logic line_r;
      logic bad_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          line_r <= 1'b0;
          bad_r  <= 1'b0;
        end else begin
          line_r <= line_g;
          bad_r  <= bad_g;
        end
      end
      assign man_out  = line_r;
      assign code_err = bad_r;
    end else begin : g_direct
      assign man_out  = line_g;
      assign code_err = bad_g;
    end
  endgenerate
endmodule

// File: rtl/mce_encoder_chk.sv
// Property checker for mce_encoder, attached by bind.
module mce_encoder_chk
  import mce_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
) (
  input logic   clk,
  input logic   rst,
  input logic   nrz_in,
  input logic   man_out,
  input logic   code_err,
  input phase_t phase
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs quiet under reset
  always @(posedge clk) begin
    if (REG_OUT ? rst_d : rst) begin
      a_r1_reset_quiet: assert (!man_out && !code_err)
        else $error("a_r1_reset_quiet");
    end
  end

  a_r2_zero_enters_tail: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_START && !nrz_in) |=> phase == PH_ZERO_TAIL);

  a_r3_one_enters_tail: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_START && nrz_in) |=> phase == PH_ONE_TAIL);

  a_r4_tail_returns: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_START) |=> phase == PH_START);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    code_err |=> !code_err);

  generate
    if (REG_OUT) begin : g_reg_chk
      a_r5_flag_broken_tail: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_ZERO_TAIL && nrz_in) || (phase == PH_ONE_TAIL && !nrz_in))
        |=> (code_err && !man_out));
      a_r7_first_half_late: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_START) |=> (man_out == $past(nrz_in) && !code_err));
    end else begin : g_dir_chk
      a_r5_flag_broken_tail: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_ZERO_TAIL && nrz_in) || (phase == PH_ONE_TAIL && !nrz_in))
        |-> (code_err && !man_out));
      a_r6_first_half_clean: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_START) |-> (man_out == nrz_in && !code_err));
    end
  endgenerate
endmodule

bind mce_encoder mce_encoder_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .nrz_in   (nrz_in),
  .man_out  (man_out),
  .code_err (code_err),
  .phase    (phase_q)
);

// File: tb/mce_encoder_tb.sv
module mce_encoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrz = 1'b0;
  logic m_line, m_err, r_line, r_err;

  always #4 clk = ~clk; // 125 MHz

  mce_encoder #(.REG_OUT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .nrz_in(nrz), .man_out(m_line), .code_err(m_err));
  mce_encoder #(.REG_OUT(1'b1)) u_dut_reg (
    .clk(clk), .rst(rst), .nrz_in(nrz), .man_out(r_line), .code_err(r_err));

  typedef struct {
    logic  line;
    logic  err;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   m_st     = 0;   // 0 bit start, 1 after first-half 0, 2 after first-half 1
  bit   after_rst = 1'b1;
  bit   done = 1'b0;

  task automatic check(string tag, logic al, logic ae, logic el, logic ee);
    n_checks++;
    if ({al, ae} !== {el, ee}) begin
      n_fail++;
      $display("FAIL %s: line=%b err=%b, expected line=%b err=%b", tag, al, ae, el, ee);
    end
  endtask

  // driver: one half-bit sample per clock, expected result to the scoreboard
  task automatic drive(input logic b, input logic r);
    exp_t e;
    @(negedge clk);
    rst = r;
    nrz = b;
    if (r) begin
      e = '{1'b0, 1'b0, "R1"};
      m_st = 0;
      after_rst = 1'b1;
    end else if (m_st == 0) begin
      e = '{b, 1'b0, after_rst ? "R8" : (b ? "R3 R4 R6" : "R2 R4 R6")};
      m_st = b ? 2 : 1;
      after_rst = 1'b0;
    end else if (m_st == 1) begin
      e = b ? '{1'b0, 1'b1, "R5"} : '{1'b1, 1'b0, "R2 R6"};
      m_st = 0;
    end else begin
      e = b ? '{1'b0, 1'b0, "R3 R6"} : '{1'b0, 1'b1, "R5"};
      m_st = 0;
    end
    q.push_back(e);
  endtask

  task automatic send_bit(input logic b);
    drive(b, 1'b0);
    drive(b, 1'b0);
  endtask

  // monitor: compares both timing variants against the scoreboard
  initial begin
    exp_t cur, prev;
    bit have_prev = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        cur = q.pop_front();
        check($sformatf("%s direct", cur.tag), m_line, m_err, cur.line, cur.err);
        if (have_prev)
          check($sformatf("R7 lagged %s", prev.tag), r_line, r_err, prev.line, prev.err);
        prev = cur;
        have_prev = 1'b1;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) drive(1'b0, 1'b1);
    // R8, R2, R3: fixed patterns
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b1);
    // R5: broken tails, each followed by a legal bit (R4)
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); send_bit(1'b1);
    drive(1'b1, 1'b0); drive(1'b0, 1'b0); send_bit(1'b0);
    drive(1'b1, 1'b0); drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b0, 1'b0);
    // R1 with R5 in the same cycle: reset wins
    drive(1'b0, 1'b0); drive(1'b1, 1'b1); send_bit(1'b1);
    drive(1'b1, 1'b0); drive(1'b0, 1'b1); send_bit(1'b0);
    // R8: reset mid-bit, then a fresh bit
    drive(1'b1, 1'b0); drive(1'b1, 1'b1); drive(1'b1, 1'b1); send_bit(1'b0);
    // random data stream with occasional broken pairs
    for (int i = 0; i < 400; i++) begin
      logic b;
      b = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 19) == 0) begin
        drive(b, 1'b0);
        drive(~b, 1'b0);
      end else begin
        send_bit(b);
      end
    end
    drive(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule